// File: doc/BRIEF.md
# Register-Programmed SPI Master with Receive-Level Interrupt

This block is an SPI master that a processor drives through a small register bank on a simple 32-bit bus. The bus has a byte address, a write strobe with write data, and a read strobe with combinational read data. Software picks one of two operating modes. In config mode it sets the serial clock divider, the word length (8 or 16 bits), the clock polarity, the clock phase and the shift order. In active mode every word written to the data register enters a four-entry transmit FIFO. The shifter takes words from that FIFO one at a time and shifts them out. It shifts a word in at the same time and pushes that word into a four-entry receive FIFO.

Reading the data register pops the receive FIFO. A status register reports both FIFO fill levels and whether the shifter is idle. It also has a flag that is set once the receive FIFO holds at least a programmed number of words. A level interrupt follows that flag when software has enabled it. Chip select is not part of the block; external logic drives it.

The shifter is a three-state machine. SH_IDLE waits. Its transition "start" goes to SH_SHIFT when the mode is active, no stop is requested and the transmit FIFO is not empty; the head word is popped on that transition. SH_SHIFT produces one serial clock period of div+1 base clocks per bit. Its transition "last tick" goes to SH_DONE at the end of the final bit's period. SH_DONE pushes the received word and always returns to SH_IDLE through the transition "retire".

Top module: `spim_ctrl`

## Requirements
- R1: After reset the mode control register (offset 0x00) reads 0x40 (config mode), control 1 (offset 0x08) reads 0x0108 (divider 1, 8-bit words), status (offset 0x14) reads 0x0004 (idle, both FIFOs empty), and irq and sclk are low.
- R2: Mode control bits [7:6] select the mode: 01 config, 10 active, other codes neither. Control 1 writes are honoured only in config mode, and so are the control 0 writes to polarity (bit 0), phase (bit 1) and shift order (bit 2, 1 = MSB first). In any other mode these fields keep their old values.
- R3: The control 1 divider field in bits [15:8] sets each serial bit period to divider+1 base clocks. A written divider of 0 is stored as 1. The word-length field in bits [4:0] accepts only 8 or 16; any other value leaves the length unchanged.
- R4: Each transmitted 8-bit word goes out full duplex with the configured polarity, phase and order, and the slave captures exactly the written word. The word received from the slave in the same transfer is pushed into the receive FIFO.
- R5: With 16-bit words, all 16 bits are exchanged in both directions in every polarity, phase and order combination.
- R6: Shifting starts only in active mode. Words written in any other mode wait in the transmit FIFO, and the shifter stays idle.
- R7: The transmit FIFO holds 4 words. A data write while it is full is dropped, and the dropped word is never sent.
- R8: A read of the data register (offset 0x18) pops the oldest received word. A read while the receive FIFO is empty returns 0.
- R9: Status bit 2 is high only while the shifter is in SH_IDLE, bits [10:8] give the receive FIFO count, and bits [13:11] give the transmit FIFO count.
- R10: Status bit 14 is set while the receive count is at least control 0 bits [13:12] plus one. The irq output equals that flag ANDed with control 0 bit 9. Both of these control 0 fields can be written in any mode.
- R11: Writing mode control with bit 0 set empties both FIFOs in that cycle. The bit does not stay set and reads back as 0.
- R12: While mode control bit 1 (stop) is set, no new word is started. Clearing it lets pending words go.
- R13: Whenever the shifter is idle, sclk sits at the polarity level from control 0 bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; also the source of the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; pops the receive FIFO when addressing data |
| rd_data | output | 32 | Combinational read data for addr |
| irq | output | 1 | Level interrupt: receive level reached and enabled |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The bench attaches a slave model that shifts a known word sequence back and records what it captures on mosi. Random bursts of one to four words, with random polarity, phase, order, width and small dividers, check both directions at once. A phase error corrupts the captured words, an order error mirrors them, and a width error truncates them. Directed cases fill the transmit FIFO past four in config mode to separate queuing from shifting and dropping. They time the gap between leading edges at two dividers, including the clamped zero. They also walk the receive count across the programmed level with the interrupt enable toggled, and they apply stop and clear to show that each acts on its own.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam logic [7:0] OFF_MCTL = 8'h00;
    localparam logic [7:0] OFF_CTL0 = 8'h04;
    localparam logic [7:0] OFF_CTL1 = 8'h08;
    localparam logic [7:0] OFF_STAT = 8'h14;
    localparam logic [7:0] OFF_DATA = 8'h18;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_CFG  = 2'b01,
        MODE_ACT  = 2'b10,
        MODE_BAD  = 2'b11
    } spim_mode_e;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_DONE  = 2'd2
    } spim_state_e;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter  int W     = 16,
    parameter  int DEPTH = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter  int DW    = 16,
    parameter  int DIV_W = 8,
    localparam int BW    = $clog2(DW),
    localparam int HW    = DW / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_ok,
    input  logic             tx_avail,
    input  logic [DW-1:0]    tx_word,
    input  logic [DIV_W-1:0] div,
    input  logic             wide,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             msb_first,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [DW-1:0]    rx_word,
    output logic             idle,
    output logic             sclk,
    output logic             mosi
);

    spim_state_e      state, state_n;
    logic [DIV_W-1:0] cnt;
    logic [BW-1:0]    bidx;
    logic [DW-1:0]    sh, sh_adv, rx, rx_adv;
    logic             act, mosi_q;
    logic [DIV_W:0]   div_p1;
    logic [DIV_W-1:0] half;
    logic             lead, trail, tick_end, last_bit;

    function automatic logic out_bit(input logic [DW-1:0] v, input logic msb, input logic wd);
        if (!msb)     return v[0];
        else if (wd)  return v[DW-1];
        else          return v[HW-1];
    endfunction

    assign div_p1   = {1'b0, div} + 1'b1;
    assign half     = div_p1[DIV_W:1];
    assign lead     = (state == SH_SHIFT) && (cnt == '0);
    assign trail    = (state == SH_SHIFT) && (cnt == half);
    assign tick_end = (state == SH_SHIFT) && (cnt == div);
    assign last_bit = (bidx == (wide ? BW'(DW - 1) : BW'(HW - 1)));
    assign sh_adv   = msb_first ? (sh << 1) : (sh >> 1);
    assign rx_adv   = msb_first ? {rx[DW-2:0], miso} : {miso, rx[DW-1:1]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_n;
    end

    // transitions: start, last tick, retire
    always_comb begin
        state_n = state;
        unique case (state)
            SH_IDLE:  if (go_ok && tx_avail)     state_n = SH_SHIFT;
            SH_SHIFT: if (tick_end && last_bit)  state_n = SH_DONE;
            SH_DONE:                             state_n = SH_IDLE;
            default:                             state_n = SH_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            bidx   <= '0;
            sh     <= '0;
            rx     <= '0;
            act    <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    act <= 1'b0;
                    if (state_n == SH_SHIFT) begin
                        sh   <= tx_word;
                        cnt  <= '0;
                        bidx <= '0;
                        rx   <= '0;
                        if (!cpha) mosi_q <= out_bit(tx_word, msb_first, wide);
                    end
                end
                SH_SHIFT: begin
                    if (tick_end) begin
                        cnt  <= '0;
                        bidx <= bidx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    if (lead) begin
                        act <= 1'b1;
                        if (!cpha) begin
                            rx <= rx_adv;
                        end else begin
                            mosi_q <= out_bit(sh, msb_first, wide);
                            sh     <= sh_adv;
                        end
                    end
                    if (trail) begin
                        act <= 1'b0;
                        if (cpha) begin
                            rx <= rx_adv;
                        end else if (!last_bit) begin
                            sh     <= sh_adv;
                            mosi_q <= out_bit(sh_adv, msb_first, wide);
                        end
                    end
                end
                SH_DONE: act <= 1'b0;
                default: act <= 1'b0;
            endcase
        end
    end

    assign tx_pop  = (state == SH_IDLE) && (state_n == SH_SHIFT);
    assign rx_push = (state == SH_DONE);
    assign idle    = (state == SH_IDLE);
    assign sclk    = cpol ^ act;
    assign mosi    = mosi_q;
    assign rx_word = wide      ? rx :
                     msb_first ? {{HW{1'b0}}, rx[HW-1:0]} :
                                 {{HW{1'b0}}, rx[DW-1:HW]};

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int DW     = 16,
    parameter  int DIV_W  = 8,
    parameter  int DEPTH  = 4,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    spim_mode_e       mode_q;
    logic             stop_q, cpol_q, cpha_q, msb_q, ie_q, wide_q;
    logic [1:0]       lvl_q;
    logic [DIV_W-1:0] div_q;

    logic             hit_mctl, hit_ctl0, hit_ctl1, hit_stat, hit_data;
    logic             in_cfg, fifo_clr, lvl_hit;
    logic             tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty, rx_pop;
    logic [DW-1:0]    tx_head, rx_head, rx_word;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    logic             sh_idle;

    assign hit_mctl = (addr == ADDR_W'(OFF_MCTL));
    assign hit_ctl0 = (addr == ADDR_W'(OFF_CTL0));
    assign hit_ctl1 = (addr == ADDR_W'(OFF_CTL1));
    assign hit_stat = (addr == ADDR_W'(OFF_STAT));
    assign hit_data = (addr == ADDR_W'(OFF_DATA));
    assign in_cfg   = (mode_q == MODE_CFG);
    assign fifo_clr = wr_en && hit_mctl && wr_data[0];
    assign rx_pop   = rd_en && hit_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_CFG;
            stop_q <= 1'b0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            msb_q  <= 1'b0;
            ie_q   <= 1'b0;
            lvl_q  <= 2'd0;
            div_q  <= DIV_W'(1);
            wide_q <= 1'b0;
        end else if (wr_en) begin
            if (hit_mctl) begin
                mode_q <= spim_mode_e'(wr_data[7:6]);
                stop_q <= wr_data[1];
            end
            if (hit_ctl0) begin
                ie_q  <= wr_data[9];
                lvl_q <= wr_data[13:12];
                if (in_cfg) begin
                    cpol_q <= wr_data[0];
                    cpha_q <= wr_data[1];
                    msb_q  <= wr_data[2];
                end
            end
            if (hit_ctl1 && in_cfg) begin
                div_q <= (wr_data[8 +: DIV_W] == '0) ? DIV_W'(1) : wr_data[8 +: DIV_W];
                if (wr_data[4:0] == 5'(DW))          wide_q <= 1'b1;
                else if (wr_data[4:0] == 5'(DW / 2)) wide_q <= 1'b0;
            end
        end
    end

    spim_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(wr_en && hit_data), .din(wr_data[DW-1:0]),
        .pop(tx_pop), .dout(tx_head), .cnt(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_head), .cnt(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    spim_shifter #(.DW(DW), .DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .go_ok((mode_q == MODE_ACT) && !stop_q),
        .tx_avail(!tx_empty), .tx_word(tx_head),
        .div(div_q), .wide(wide_q), .cpol(cpol_q), .cpha(cpha_q),
        .msb_first(msb_q), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .idle(sh_idle), .sclk(sclk), .mosi(mosi)
    );

    assign lvl_hit = int'(rx_cnt) > int'(lvl_q);
    assign irq     = lvl_hit && ie_q;

    always_comb begin
        rd_data = '0;
        if (hit_mctl) begin
            rd_data[7:6] = mode_q;
            rd_data[1]   = stop_q;
        end else if (hit_ctl0) begin
            rd_data[13:12] = lvl_q;
            rd_data[9]     = ie_q;
            rd_data[2:0]   = {msb_q, cpha_q, cpol_q};
        end else if (hit_ctl1) begin
            rd_data[8 +: DIV_W] = div_q;
            rd_data[4:0]        = wide_q ? 5'(DW) : 5'(DW / 2);
        end else if (hit_stat) begin
            rd_data[14]    = lvl_hit;
            rd_data[13:11] = 3'(tx_cnt);
            rd_data[10:8]  = 3'(rx_cnt);
            rd_data[2]     = sh_idle;
        end else if (hit_data) begin
            rd_data[DW-1:0] = rx_head;
        end
    end

endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
    import spim_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic       clk,
    input logic       rst_n,
    input spim_mode_e mode_q,
    input logic       stop_q,
    input logic [7:0] div_q,
    input logic       wide_q,
    input logic       cpol_q,
    input logic       ie_q,
    input logic [1:0] lvl_q,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic       sh_idle,
    input logic       sclk,
    input logic       irq,
    input logic [7:0] addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data
);

    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ACT) |=> ($stable(div_q) && $stable(wide_q)));

    a_r6_start_active: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh_idle) |-> ($past(mode_q) == MODE_ACT && !$past(stop_q)));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_cnt) <= DEPTH) && (int'(rx_cnt) <= DEPTH));

    a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFF_DATA && rx_cnt == '0) |-> (rd_data == 32'd0));

    a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_q && int'(rx_cnt) > int'(lvl_q)));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_MCTL && wr_data[0]) |=> (tx_cnt == '0 && rx_cnt == '0));

    a_r13_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sh_idle |-> (sclk == cpol_q));

endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .stop_q(stop_q),
    .div_q(div_q), .wide_q(wide_q), .cpol_q(cpol_q), .ie_q(ie_q),
    .lvl_q(lvl_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .sh_idle(sh_idle),
    .sclk(sclk), .irq(irq), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
);

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq, sclk, mosi;
    logic        miso = 1'b0;

    always #10 clk = ~clk;

    spim_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_tb();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // ---------------- slave model ----------------
    bit          s_en = 0, s_cpol = 0, s_cpha = 0, s_msb = 0, s_wide = 0;
    int          s_k = 0, s_bits = 0, cap_n = 0;
    logic [15:0] s_sh = '0, s_cap = '0;
    logic [15:0] cap [0:7];
    time         t_prev = 0, t_last = 0;

    function automatic logic [15:0] sw(input int k, input bit wd);
        logic [15:0] v = 16'(k * 32'h3A5B + 32'h1234);
        return wd ? v : {8'h00, v[7:0]};
    endfunction
    function automatic logic sbit(input logic [15:0] v);
        return !s_msb ? v[0] : (s_wide ? v[15] : v[7]);
    endfunction
    function automatic logic [15:0] s_fix(input logic [15:0] v);
        if (s_wide) return v;
        return s_msb ? {8'h00, v[7:0]} : {8'h00, v[15:8]};
    endfunction

    always @(sclk) begin
        if (s_en) begin
            if (sclk !== s_cpol) begin
                t_prev = t_last;
                t_last = $time;
                if (!s_cpha) begin
                    s_cap = s_msb ? {s_cap[14:0], mosi} : {mosi, s_cap[15:1]};
                    s_bits++;
                end else begin
                    if (s_bits == 0) s_sh = sw(s_k, s_wide);
                    else             s_sh = s_msb ? s_sh << 1 : s_sh >> 1;
                    miso = sbit(s_sh);
                end
            end else begin
                if (!s_cpha) begin
                    if (s_bits == (s_wide ? 16 : 8)) begin
                        if (cap_n < 8) cap[cap_n] = s_fix(s_cap);
                        cap_n++;
                        s_bits = 0;
                        s_k++;
                        s_sh = sw(s_k, s_wide);
                    end else begin
                        s_sh = s_msb ? s_sh << 1 : s_sh >> 1;
                    end
                    miso = sbit(s_sh);
                end else begin
                    s_cap = s_msb ? {s_cap[14:0], mosi} : {mosi, s_cap[15:1]};
                    s_bits++;
                    if (s_bits == (s_wide ? 16 : 8)) begin
                        if (cap_n < 8) cap[cap_n] = s_fix(s_cap);
                        cap_n++;
                        s_bits = 0;
                        s_k++;
                    end
                end
            end
        end
    end

    task automatic prime(input int k);
        s_k = k; s_bits = 0; s_cap = '0; cap_n = 0;
        s_sh = sw(k, s_wide);
        miso = s_cpha ? 1'b0 : sbit(s_sh);
        s_en = 1;
    endtask

    // ---------------- bus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] st;
        do rd(8'h14, st); while (!(st[13:11] == 3'd0 && st[2]));
    endtask

    task automatic configure(input bit cp, input bit ph, input bit mf, input bit wd, input int dv);
        wr(8'h00, 32'h40);
        wr(8'h04, {29'd0, mf, ph, cp});
        wr(8'h08, {16'd0, 8'(dv), 3'd0, wd ? 5'd16 : 5'd8});
        s_cpol = cp; s_cpha = ph; s_msb = mf; s_wide = wd;
    endtask

    int nk = 100;

    task automatic burst(input int cnt, input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input logic [15:0] w3);
        logic [15:0] ws [4];
        logic [15:0] m;
        logic [31:0] d;
        string tag;
        ws[0] = w0; ws[1] = w1; ws[2] = w2; ws[3] = w3;
        m = s_wide ? 16'hFFFF : 16'h00FF;
        tag = s_wide ? "R5" : "R4";
        prime(nk);
        wr(8'h00, 32'h80);
        for (int i = 0; i < cnt; i++) wr(8'h18, {16'd0, ws[i]});
        wait_done();
        s_en = 0;
        chk({tag, " words captured"}, 32'(cap_n), 32'(cnt));
        for (int i = 0; i < cnt; i++) chk({tag, " slave capture"}, {16'd0, cap[i]}, {16'd0, ws[i] & m});
        rd(8'h14, d);
        chk("R9 rx count", {29'd0, d[10:8]}, 32'(cnt));
        for (int i = 0; i < cnt; i++) begin
            rd(8'h18, d);
            chk({tag, " received word"}, d, {16'd0, sw(nk + i, s_wide)});
        end
        nk += cnt;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_tb();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); chk("R1 mode ctl", d, 32'h40);
        rd(8'h08, d); chk("R1 ctl1", d, 32'h0108);
        rd(8'h14, d); chk("R1 status", d, 32'h0004);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 sclk", {31'd0, sclk}, 0);

        // R3 divider clamp and bit period
        configure(0, 0, 1, 1, 0);
        rd(8'h08, d); chk("R3 div 0 clamps to 1", d, 32'h0110);
        burst(1, 16'hA5C3, 0, 0, 0);
        chk("R3 period div1", 32'((t_last - t_prev) / 20), 2);
        configure(1, 1, 0, 1, 5);
        burst(1, 16'h1F2E, 0, 0, 0);
        chk("R3 period div5", 32'((t_last - t_prev) / 20), 6);
        wr(8'h00, 32'h40);
        wr(8'h08, 32'h0307);
        rd(8'h08, d); chk("R3 bad length kept", d, 32'h0310);

        // R2 config-only fields ignored in active
        configure(0, 0, 1, 0, 2);
        wr(8'h00, 32'h80);
        wr(8'h08, 32'h0A10);
        rd(8'h08, d); chk("R2 ctl1 locked", d, 32'h0208);
        wr(8'h04, 32'h0001);
        rd(8'h04, d); chk("R2 ctl0 locked", d, 32'h0004);
        chk("R13 sclk idle low", {31'd0, sclk}, 0);
        wr(8'h00, 32'h40);
        wr(8'h04, 32'h0005);
        chk("R13 sclk idle follows cpol", {31'd0, sclk}, 1);

        // R6 / R7 queue in config, drop on full
        configure(0, 1, 1, 0, 1);
        for (int i = 0; i < 5; i++) wr(8'h18, 32'h10 + i);
        repeat (10) @(negedge clk);
        rd(8'h14, d);
        chk("R6 no shift in config (idle)", {31'd0, d[2]}, 1);
        chk("R7 tx count capped", {29'd0, d[13:11]}, 4);
        prime(nk);
        wr(8'h00, 32'h80);
        wait_done();
        s_en = 0;
        chk("R7 four words sent", 32'(cap_n), 4);
        chk("R7 fifth dropped", {16'd0, cap[3]}, 32'h13);
        for (int i = 0; i < 4; i++) begin
            rd(8'h18, d);
            chk("R8 pop order", d, {16'd0, sw(nk + i, 0)});
        end
        nk += 4;
        rd(8'h18, d); chk("R8 empty read zero", d, 0);

        // R12 stop
        configure(0, 0, 0, 0, 1);
        prime(nk);
        wr(8'h00, 32'h82);
        wr(8'h18, 32'h5A);
        repeat (40) @(negedge clk);
        rd(8'h14, d);
        chk("R12 held by stop", {26'd0, d[13:11], d[2:0]}, {26'd0, 3'd1, 3'b100});
        wr(8'h00, 32'h80);
        wait_done();
        s_en = 0;
        chk("R12 resumes", 32'(cap_n), 1);
        rd(8'h18, d);
        nk += 1;

        // R10 receive level and irq
        wr(8'h04, 32'h1200);
        wr(8'h18, 32'h01);
        wait_done();
        rd(8'h14, d);
        chk("R10 below level flag", {31'd0, d[14]}, 0);
        chk("R10 below level irq", {31'd0, irq}, 0);
        wr(8'h18, 32'h02);
        wait_done();
        rd(8'h14, d);
        chk("R10 level flag", {31'd0, d[14]}, 1);
        chk("R10 irq", {31'd0, irq}, 1);
        wr(8'h04, 32'h1000);
        chk("R10 irq masked", {31'd0, irq}, 0);
        rd(8'h14, d); chk("R10 flag kept", {31'd0, d[14]}, 1);
        rd(8'h18, d);
        rd(8'h14, d); chk("R10 flag drops", {31'd0, d[14]}, 0);

        // R11 clear
        wr(8'h00, 32'h40);
        wr(8'h18, 32'h77);
        wr(8'h18, 32'h78);
        wr(8'h00, 32'h41);
        rd(8'h14, d); chk("R11 both empty", {26'd0, d[13:8]}, 0);
        rd(8'h00, d); chk("R11 self clear", d, 32'h40);
        rd(8'h18, d); chk("R11 rx flushed", d, 0);

        // random bursts R4 / R5
        for (int b = 0; b < 24; b++) begin
            bit cp = 1'($urandom), ph = 1'($urandom), mf = 1'($urandom), wd = 1'($urandom);
            int dv = $urandom_range(0, 3);
            int cnt = $urandom_range(1, 4);
            configure(cp, ph, mf, wd, dv);
            burst(cnt, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
            chk("R13 sclk at polarity", {31'd0, sclk}, {31'd0, cp});
        end

        finish_tb();
    end

endmodule